// File: doc/BRIEF.md
# Serial-Tagged Conditional-Store Memory

This block is a small word memory. Every word carries its own write counter, and the counter replaces reservation bits. Any write that lands on a word advances that word's counter by one.

A requester that wants an atomic read-modify-write first issues a linked load. The linked load returns the word together with its current serial. The requester then issues a conditional store with the new value and the serial it expects. The store takes effect only if the word's counter still equals that serial. Because nothing is reserved, a conditional store may be issued with no linked load before it; any requester that knows the current serial may use it. Rewriting a word with its old value still advances the counter, so a stale conditional store is always caught.

Requests use a valid/ready handshake and are served one at a time. Every accepted request yields exactly one response cycle that carries data, serial and a success flag.

The controller is a three-state machine:

- IDLE accepts a request. It moves to EXEC on `req_valid && req_ready`, and otherwise stays in IDLE.
- EXEC reads the word and its counter, decides whether to write, and registers the response. It always moves to REPLY.
- REPLY presents the response for one cycle and always returns to IDLE.

Top module: `seqtag_mem`

## Requirements
- R1: After reset every word holds zero, every counter holds zero, `req_ready` is 1 and `rsp_valid` is 0.
- R2: A plain load (`req_op`=0) returns the word's data and its current serial with `rsp_ok`=1. It changes neither the data nor the counter.
- R3: A linked load (`req_op`=2) returns the same data and serial as a plain load with `rsp_ok`=1, and changes nothing.
- R4: A plain store (`req_op`=1) writes `req_data`, increments that word's counter, and responds with `rsp_ok`=1, the written data and the new serial.
- R5: A conditional store (`req_op`=3) whose `req_serial` equals the word's counter writes `req_data` and increments the counter in the same operation. It responds with `rsp_ok`=1, the written data and the new serial.
- R6: A conditional store whose `req_serial` differs from the counter changes neither data nor counter. It responds with `rsp_ok`=0, the current data and the current serial.
- R7: A conditional store succeeds without any earlier linked load when it carries the matching serial.
- R8: A store that writes back the unchanged value still advances the serial, so a conditional store that carries the older serial fails.
- R9: The counter wraps from all ones to zero, with no error indication.
- R10: A request is accepted only while `req_ready` is 1. `req_ready` is 0 during the two cycles after acceptance. `rsp_valid` is 1 for exactly the second of those cycles.
- R11: Counters and data are kept per word. An operation on one address leaves every other word's data and serial unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 load, 1 store, 2 linked load, 3 conditional store |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Data to write |
| req_serial | input | SER_W | Expected serial for a conditional store |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_ok | output | 1 | 0 only for a failed conditional store |
| rsp_data | output | DATA_W | Word value after the operation |
| rsp_serial | output | SER_W | Word serial after the operation |

## Verification
A counter that advances on the wrong operation, or on the wrong address, shows at the ports on the next access to that word. A later load returns an unexpected serial, or a conditional store that should succeed fails. A failed conditional store that wrongly writes shows up in the data of the following load to that word. A state-machine fault shows within one cycle as a mismatch of `req_ready` or `rsp_valid` against the two-cycle busy window. The bench compares these outputs with its model on every clock.

// File: rtl/seqtag_pkg.sv
package seqtag_pkg;
    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_LINK  = 2'd2,
        OP_COND  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXEC  = 2'd1,
        ST_REPLY = 2'd2
    } state_e;
endpackage

// File: rtl/seqtag_bank.sv
module seqtag_bank #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int SER_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [SER_W-1:0]  rd_ser,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];
    logic [SER_W-1:0]  ser_q  [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[e] <= '0;
                ser_q[e]  <= '0;
            end else if (wr_en && (wr_addr == ADDR_W'(e))) begin
                word_q[e] <= wr_data;
                ser_q[e]  <= ser_q[e] + 1'b1;
            end
        end
    end

    assign rd_data = word_q[rd_addr];
    assign rd_ser  = ser_q[rd_addr];

    // R4
    ser_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ser_q[$past(wr_addr)] == SER_W'($past(ser_q[wr_addr]) + 1'b1)));

    // R2
    ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (ser_q[$past(rd_addr)] == $past(rd_ser)));
endmodule

// File: rtl/seqtag_ctrl.sv
module seqtag_ctrl
    import seqtag_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int SER_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [SER_W-1:0]  req_serial,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_data,
    output logic [SER_W-1:0]  rsp_serial,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [SER_W-1:0]  rd_ser,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    state_e            state_q, state_d;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [SER_W-1:0]  exp_q;
    logic              match;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_EXEC;
            ST_EXEC:  state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = (state_q == ST_REPLY);
    assign rd_addr   = addr_q;
    assign wr_addr   = addr_q;
    assign wr_data   = data_q;
    assign match     = (rd_ser == exp_q);
    assign wr_en     = (state_q == ST_EXEC) &&
                       ((op_q == OP_STORE) || ((op_q == OP_COND) && match));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_LOAD;
            addr_q     <= '0;
            data_q     <= '0;
            exp_q      <= '0;
            rsp_ok     <= 1'b0;
            rsp_data   <= '0;
            rsp_serial <= '0;
        end else begin
            if (req_valid && req_ready) begin
                op_q   <= op_e'(req_op);
                addr_q <= req_addr;
                data_q <= req_data;
                exp_q  <= req_serial;
            end
            if (state_q == ST_EXEC) begin
                if (wr_en) begin
                    rsp_ok     <= 1'b1;
                    rsp_data   <= data_q;
                    rsp_serial <= rd_ser + 1'b1;
                end else begin
                    rsp_ok     <= (op_q != OP_COND);
                    rsp_data   <= rd_data;
                    rsp_serial <= rd_ser;
                end
            end
        end
    end

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    reply_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (req_ready && !rsp_valid));

    // R6
    cond_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (op_q == OP_COND) && !rsp_ok) |-> (rsp_serial != exp_q));

    // R5
    cond_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (op_q == OP_COND) && rsp_ok) |-> (rsp_serial == SER_W'(exp_q + 1'b1)));
endmodule

// File: rtl/seqtag_mem.sv
module seqtag_mem #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int SER_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [SER_W-1:0]  req_serial,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [DATA_W-1:0] rsp_data,
    output logic [SER_W-1:0]  rsp_serial
);
    logic [ADDR_W-1:0] rd_addr, wr_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic [SER_W-1:0]  rd_ser;
    logic              wr_en;

    seqtag_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SER_W(SER_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_serial(req_serial),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .rsp_serial(rsp_serial),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_ser(rd_ser),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    seqtag_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SER_W(SER_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_data(rd_data), .rd_ser(rd_ser),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );
endmodule

// File: tb/seqtag_mem_test.sv
module seqtag_mem_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 32;
    localparam int SW = 4;   // narrow serial so wrap is reachable (R9)
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [SW-1:0] req_serial = '0;
    logic          rsp_valid, rsp_ok;
    logic [DW-1:0] rsp_data;
    logic [SW-1:0] rsp_serial;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int acc_cyc = -10;
    bit done = 1'b0;

    int unsigned m_data [DEPTH];
    int unsigned m_ser  [DEPTH];
    int unsigned e_data, e_ser;
    bit          e_ok;
    string       e_tag = "R10";

    seqtag_mem #(.ADDR_W(AW), .DATA_W(DW), .SER_W(SW)) uut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_serial(req_serial),
        .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
        .rsp_serial(rsp_serial)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-clock comparison of handshake and response against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit busy, rv;
            busy = (cyc == acc_cyc) || (cyc == acc_cyc + 1);
            rv   = (cyc == acc_cyc + 1);
            check("R10", "req_ready", req_ready, !busy);
            check("R10", "rsp_valid", rsp_valid, rv);
            if (rv && rsp_valid) begin
                check(e_tag, "rsp_ok", rsp_ok, e_ok);
                check(e_tag, "rsp_data", rsp_data, e_data);
                check(e_tag, "rsp_serial", rsp_serial, e_ser);
            end
        end
    end

    task automatic issue(string tag, int op, int addr, int unsigned data, int unsigned ser);
        int unsigned mask;
        mask = (1 << SW) - 1;
        @(negedge clk);
        case (op)
            1: begin
                m_data[addr] = data; m_ser[addr] = (m_ser[addr] + 1) & mask;
                e_ok = 1'b1;
            end
            3: if (m_ser[addr] == ser) begin
                m_data[addr] = data; m_ser[addr] = (m_ser[addr] + 1) & mask;
                e_ok = 1'b1;
            end else e_ok = 1'b0;
            default: e_ok = 1'b1;
        endcase
        e_data = m_data[addr];
        e_ser  = m_ser[addr];
        e_tag  = tag;
        req_valid = 1'b1; req_op = op[1:0]; req_addr = addr[AW-1:0];
        req_data = data; req_serial = ser[SW-1:0];
        @(posedge clk);
        acc_cyc = cyc + 1;
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        @(posedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = 0; m_ser[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset req_ready", req_ready, 1);
        check("R1", "reset rsp_valid", rsp_valid, 0);
        rst_n = 1'b1;
        issue("R1", 0, 3, 0, 0);                    // zero data, zero serial
        issue("R4", 1, 3, 32'hA5A5_0001, 0);        // store -> serial 1
        issue("R2", 0, 3, 0, 0);                    // load sees it, no change
        issue("R2", 0, 3, 0, 0);
        issue("R3", 2, 3, 0, 0);                    // linked load
        issue("R5", 3, 3, 32'hBEEF_0002, 1);        // matching cond -> serial 2
        issue("R6", 3, 3, 32'hDEAD_0003, 1);        // stale cond fails
        issue("R6", 0, 3, 0, 0);                    // nothing written
        issue("R7", 3, 7, 32'h7777_0007, 0);        // bare cond on fresh word
        issue("R8", 2, 5, 0, 0);                    // link: data 0 serial 0
        issue("R8", 1, 5, 0, 0);                    // same value rewritten
        issue("R8", 3, 5, 32'h5555_0005, 0);        // old serial must fail
        for (int k = 0; k < (1 << SW); k++)
            issue("R9", 1, 9, 32'h9000_0000 + k, 0);
        issue("R9", 0, 9, 0, 0);                    // serial wrapped to zero
        issue("R9", 3, 9, 32'h9999_9999, 0);        // cond with zero succeeds
        issue("R11", 0, 3, 0, 0);                   // untouched by others
        issue("R11", 0, 7, 0, 0);
        issue("R11", 0, 12, 0, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule